// File: doc/BRIEF.md
# DMX512 Frame Receiver

This block takes the receive line of an RS-485 transceiver, already synchronized to the system clock, and recovers DMX512 frames. It finds the break, checks that the mark-after-break lasts long enough, and then deserializes slots. Each slot is one start bit, eight data bits sent LSB first, and two stop bits, at 250 kbaud. The line is sampled with 16x oversampling, using a tick derived from the system clock.

Each received slot is written into a slot memory at the address equal to its slot number. Slot 0 holds the start code, and slots 1 onward hold channel values. Only the break returns the slot index to zero; no byte count does. A frame closes when the next break arrives or when the line stays idle for longer than a timeout. At that moment the block pulses a done strobe. It also presents the number of slots captured, a flag for any framing error in the frame, and a flag for a start code other than zero. A consumer reads the captured slots through a simple synchronous read port.

Top module: `dmx512_rx`

## Requirements
- R1: A low level lasting BRK_BITS bit times (default 12) counts as a break, even when a slot is in progress. A break resets the slot index to 0 and discards any slot whose stop bit has not yet been accepted.
- R2: After a break the line must stay high for at least MAB_BITS bit times (default 2). If it goes low sooner, the frame is ignored. While no valid break and mark have been seen, incoming bytes are ignored and no frame completes.
- R3: One bit time is 16·TICK_DIV clocks. A slot is a low start bit confirmed at mid-bit, then 8 data bits taken LSB first at mid-bit, then a stop bit sampled at mid-bit.
- R4: Slot n of a frame is stored at memory address n, with address 0 holding the start code. `rd_data` returns the entry at `rd_addr` one clock later.
- R5: A break that arrives after at least one slot has been stored closes the frame. This raises `frame_done`, and `frame_slots` gives the number of slots stored.
- R6: A high line lasting IDLE_BITS bit times after at least one slot also closes the frame. The receiver then waits for a new break.
- R7: Slots beyond SLOT_MAX (default 513) are neither written nor counted, so `frame_slots` never exceeds SLOT_MAX.
- R8: A stop bit sampled low, with the line returning high before a break, is a framing error. The slot is still stored and counted, and `frame_bad` is 1 for that frame.
- R9: `frame_alt_sc` is 1 when the start code (slot 0) of the closed frame is not 0x00.
- R10: After reset `frame_done`, `frame_slots`, `frame_bad` and `frame_alt_sc` are 0.
- R11: `frame_done` is high for exactly one clock per frame. `frame_slots`, `frame_bad` and `frame_alt_sc` hold their values until the next `frame_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx | input | 1 | Synchronized receive line, idle high |
| rd_addr | input | $clog2(SLOT_MAX) | Slot memory read address |
| rd_data | output | 8 | Slot value read, one clock after address |
| frame_done | output | 1 | One-clock strobe when a frame closes |
| frame_slots | output | $clog2(SLOT_MAX+1) | Slots stored in the closed frame |
| frame_bad | output | 1 | Closed frame contained a framing error |
| frame_alt_sc | output | 1 | Closed frame had a nonzero start code |

## Verification
A table of frames is used to exercise the main receive path. The frames differ in length: a full-size frame, short frames, a single-slot frame, and one frame longer than the memory, which shows that counting saturates. They also end in different ways, some by the following break and some by the idle timeout, which separates the two closing paths. Varying the start code and placing a bad stop bit inside a frame separate the two flags from the data path. For every slot, the stored bytes are compared against the bench's own generator, which confirms both bit order and addressing. Directed cases then try three things: a mark-after-break that is too short, followed by bytes that must be ignored; a break that cuts into a slot, which must be discarded without being flagged as an error; and the reset values.

// File: rtl/dmx_rx_pkg.sv
package dmx_rx_pkg;
    localparam int OVS = 16;
    localparam int DW  = 8;

    typedef enum logic [2:0] {
        ST_HUNT    = 3'd0,
        ST_BREAK   = 3'd1,
        ST_MAB     = 3'd2,
        ST_RUN     = 3'd3,
        ST_DATA    = 3'd4,
        ST_STOPLOW = 3'd5
    } rx_state_e;
endpackage

// File: rtl/dmx_rx_tick.sv
module dmx_rx_tick #(
    parameter int DIV = 25
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = (cnt_q == CW'(DIV - 1)) ? '0 : cnt_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign tick = (cnt_q == CW'(DIV - 1));

            AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R3
        end
    endgenerate
endmodule

// File: rtl/dmx_rx_brkdet.sv
module dmx_rx_brkdet #(
    parameter int BRK_TICKS = 192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rx,
    output logic brk
);
    localparam int LW = $clog2(BRK_TICKS + 1);
    logic [LW-1:0] low_d, low_q;

    always_comb begin
        low_d = low_q;
        if (rx)
            low_d = '0;
        else if (tick && low_q != LW'(BRK_TICKS))
            low_d = low_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) low_q <= '0;
        else        low_q <= low_d;
    end

    assign brk = tick && !rx && (low_q == LW'(BRK_TICKS - 1));

    AST_BRK_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        brk |=> !brk); // R1
endmodule

// File: rtl/dmx_rx_slot_mem.sv
module dmx_rx_slot_mem #(
    parameter int DEPTH = 513,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] mem [DEPTH];
    logic [7:0] rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
        rd_q <= mem[rd_addr];
    end

    assign rd_data = rd_q;

    AST_WR_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_addr) < DEPTH)); // R7
endmodule

// File: rtl/dmx512_rx.sv
module dmx512_rx
    import dmx_rx_pkg::*;
#(
    parameter int TICK_DIV  = 25,
    parameter int SLOT_MAX  = 513,
    parameter int BRK_BITS  = 12,
    parameter int MAB_BITS  = 2,
    parameter int IDLE_BITS = 44,
    localparam int AW = $clog2(SLOT_MAX),
    localparam int CW = $clog2(SLOT_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic          frame_done,
    output logic [CW-1:0] frame_slots,
    output logic          frame_bad,
    output logic          frame_alt_sc
);
    localparam int BRK_TICKS  = BRK_BITS * OVS;
    localparam int MAB_TICKS  = MAB_BITS * OVS;
    localparam int IDLE_TICKS = IDLE_BITS * OVS;
    localparam int TMAX       = (IDLE_TICKS > MAB_TICKS) ? IDLE_TICKS : MAB_TICKS;
    localparam int TW         = $clog2(TMAX + 1);

    typedef struct packed {
        rx_state_e     st;
        logic [3:0]    phase;
        logic [3:0]    bitn;
        logic [7:0]    shreg;
        logic [TW-1:0] tmr;
        logic [CW-1:0] cnt;
        logic          bad;
        logic          alt;
        logic          done;
        logic [CW-1:0] slots_o;
        logic          bad_o;
        logic          alt_o;
    } rx_regs_t;

    rx_regs_t d, q;

    logic          tick, brk;
    logic          commit, cerr, close;
    logic          wr_en;
    logic [AW-1:0] wr_addr;

    dmx_rx_tick #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    dmx_rx_brkdet #(.BRK_TICKS(BRK_TICKS)) u_brk (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx(rx), .brk(brk)
    );

    dmx_rx_slot_mem #(.DEPTH(SLOT_MAX), .AW(AW)) u_mem (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(q.shreg), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        commit = 1'b0;
        cerr   = 1'b0;
        close  = 1'b0;
        wr_en  = 1'b0;
        wr_addr = q.cnt[AW-1:0];

        if (brk) begin
            close = (q.cnt != '0);
            d.st  = ST_BREAK;
        end else if (tick) begin
            case (q.st)
                ST_HUNT: ;
                ST_BREAK: begin
                    if (rx) begin
                        d.st  = ST_MAB;
                        d.tmr = '0;
                    end
                end
                ST_MAB: begin
                    if (!rx)
                        d.st = ST_HUNT;
                    else if (q.tmr == TW'(MAB_TICKS - 1)) begin
                        d.st  = ST_RUN;
                        d.tmr = '0;
                    end else
                        d.tmr = q.tmr + 1'b1;
                end
                ST_RUN: begin
                    if (!rx) begin
                        d.st    = ST_DATA;
                        d.phase = '0;
                        d.bitn  = '0;
                    end else if (q.cnt != '0) begin
                        if (q.tmr == TW'(IDLE_TICKS - 1)) begin
                            close = 1'b1;
                            d.st  = ST_HUNT;
                        end else
                            d.tmr = q.tmr + 1'b1;
                    end
                end
                ST_DATA: begin
                    d.phase = q.phase + 1'b1;
                    if (q.bitn == 4'd0) begin
                        if (q.phase == 4'd7) begin
                            if (rx) begin
                                d.st  = ST_RUN;
                                d.tmr = '0;
                            end else begin
                                d.bitn  = 4'd1;
                                d.phase = '0;
                            end
                        end
                    end else if (q.phase == 4'd15) begin
                        d.phase = '0;
                        if (q.bitn == 4'd9) begin
                            if (rx) begin
                                commit = 1'b1;
                                d.st   = ST_RUN;
                                d.tmr  = '0;
                            end else
                                d.st = ST_STOPLOW;
                        end else begin
                            d.shreg = {rx, q.shreg[7:1]};
                            d.bitn  = q.bitn + 1'b1;
                        end
                    end
                end
                ST_STOPLOW: begin
                    if (rx) begin
                        commit = 1'b1;
                        cerr   = 1'b1;
                        d.st   = ST_RUN;
                        d.tmr  = '0;
                    end
                end
                default: d.st = ST_HUNT;
            endcase
        end

        if (commit) begin
            if (q.cnt < CW'(SLOT_MAX)) begin
                wr_en = 1'b1;
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == '0) d.alt = (q.shreg != 8'h00);
            end
            d.bad = q.bad | cerr;
        end

        if (close) begin
            d.done    = 1'b1;
            d.slots_o = q.cnt;
            d.bad_o   = q.bad;
            d.alt_o   = q.alt;
        end

        if (brk || close) begin
            d.cnt = '0;
            d.bad = 1'b0;
            d.alt = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign frame_done   = q.done;
    assign frame_slots  = q.slots_o;
    assign frame_bad    = q.bad_o;
    assign frame_alt_sc = q.alt_o;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done); // R11
    AST_DONE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (frame_slots != '0)); // R5
    AST_SLOTS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (int'(frame_slots) <= SLOT_MAX)); // R7
    AST_BRK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        brk |=> (q.cnt == '0 && q.st == ST_BREAK)); // R1
    AST_HUNT_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_HUNT) |-> !wr_en); // R2
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> (frame_done || $stable(frame_slots))); // R11
endmodule

// File: tb/dmx512_rx_bench.sv
module dmx512_rx_bench;
    localparam int TICK_DIV  = 2;
    localparam int SLOT_MAX  = 17;
    localparam int BRK_BITS  = 12;
    localparam int MAB_BITS  = 2;
    localparam int IDLE_BITS = 20;
    localparam int AW   = $clog2(SLOT_MAX);
    localparam int CW   = $clog2(SLOT_MAX + 1);
    localparam int BITC = 16 * TICK_DIV;

    // [31:24] slot count sent, [23:16] start code, [15:8] seed,
    // [7:1] index of slot with a bad stop bit (127 = none), [0] 1 = end by break
    localparam logic [31:0] VEC [6] = '{
        {8'd17, 8'h00, 8'h11, 7'd127, 1'b0},
        {8'd5,  8'h00, 8'h40, 7'd127, 1'b1},
        {8'd9,  8'hCC, 8'h23, 7'd127, 1'b0},
        {8'd6,  8'h00, 8'h77, 7'd3,   1'b1},
        {8'd20, 8'h00, 8'h05, 7'd127, 1'b0},
        {8'd1,  8'h00, 8'h99, 7'd127, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx = 1'b1;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic          frame_done;
    logic [CW-1:0] frame_slots;
    logic          frame_bad;
    logic          frame_alt_sc;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dmx512_rx #(
        .TICK_DIV(TICK_DIV), .SLOT_MAX(SLOT_MAX), .BRK_BITS(BRK_BITS),
        .MAB_BITS(MAB_BITS), .IDLE_BITS(IDLE_BITS)
    ) u_dmx512_rx (
        .clk(clk), .rst_n(rst_n), .rx(rx), .rd_addr(rd_addr), .rd_data(rd_data),
        .frame_done(frame_done), .frame_slots(frame_slots),
        .frame_bad(frame_bad), .frame_alt_sc(frame_alt_sc)
    );

    function automatic logic [7:0] gen(input logic [7:0] seed, input int i);
        return (seed + 8'(i * 37)) ^ 8'(i << 3);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hold(input int bits);
        repeat (bits * BITC) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit good);
        rx = 1'b0; hold(1);
        for (int i = 0; i < 8; i++) begin rx = b[i]; hold(1); end
        if (good) begin rx = 1'b1; hold(2); end
        else begin rx = 1'b0; hold(1); rx = 1'b1; hold(1); end
    endtask

    task automatic wait_done(input int max_clk, output bit got);
        got = 1'b0;
        for (int i = 0; i < max_clk; i++) begin
            @(negedge clk);
            if (frame_done) begin got = 1'b1; break; end
        end
    endtask

    task automatic rd(input int a, output logic [7:0] v);
        @(negedge clk);
        rd_addr = AW'(a);
        @(negedge clk);
        v = rd_data;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        bit got;
        logic [7:0] v;
        repeat (5) @(negedge clk);
        // R10: reset values
        chk("R10 done",  32'(frame_done), 0);
        chk("R10 slots", 32'(frame_slots), 0);
        chk("R10 bad",   32'(frame_bad), 0);
        chk("R10 alt",   32'(frame_alt_sc), 0);
        rst_n = 1'b1;
        hold(2);

        for (int k = 0; k < 6; k++) begin
            int n, stored, badpos;
            logic [7:0] sc, seed;
            bit endbrk;
            n      = int'(VEC[k][31:24]);
            sc     = VEC[k][23:16];
            seed   = VEC[k][15:8];
            badpos = int'(VEC[k][7:1]);
            endbrk = VEC[k][0];
            stored = (n > SLOT_MAX) ? SLOT_MAX : n;
            rx = 1'b0; hold(24);
            rx = 1'b1; hold(3);
            for (int s = 0; s < n; s++)
                send_byte((s == 0) ? sc : gen(seed, s), s != badpos);
            if (endbrk) begin rx = 1'b0; wait_done(1500, got); end
            else        begin rx = 1'b1; wait_done(2500, got); end
            chk(endbrk ? "R5 done by break" : "R6 done by idle", 32'(got), 1);
            chk("R7 slot count", 32'(frame_slots), 32'(stored));
            chk("R8 framing flag", 32'(frame_bad), 32'(badpos < stored));
            chk("R9 start code flag", 32'(frame_alt_sc), 32'(sc != 8'h00));
            for (int s = 0; s < stored; s++) begin
                rd(s, v);
                chk("R4 R3 slot data", 32'(v), 32'((s == 0) ? sc : gen(seed, s)));
            end
            @(negedge clk);
            chk("R11 strobe single", 32'(frame_done), 0);
            chk("R11 count held", 32'(frame_slots), 32'(stored));
        end

        // R2: mark after break too short, following bytes ignored
        rx = 1'b0; hold(24);
        rx = 1'b1; hold(1);
        send_byte(8'h00, 1'b1);
        send_byte(8'h5A, 1'b1);
        send_byte(8'hA5, 1'b1);
        rx = 1'b1;
        wait_done(2500, got);
        chk("R2 short mark ignored", 32'(got), 0);
        chk("R2 previous count kept", 32'(frame_slots), 1);

        // R1: break cutting into a slot discards it
        rx = 1'b0; hold(24);
        rx = 1'b1; hold(3);
        send_byte(8'h00, 1'b1);
        send_byte(8'h12, 1'b1);
        send_byte(8'h34, 1'b1);
        rx = 1'b0;
        wait_done(1500, got);
        chk("R1 break closes frame", 32'(got), 1);
        chk("R1 partial slot dropped", 32'(frame_slots), 3);
        chk("R1 break not framing error", 32'(frame_bad), 0);
        rd(2, v);
        chk("R1 last full slot", 32'(v), 32'h34);
        rx = 1'b1; hold(4);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule